// File: doc/BRIEF.md
# Read Latency Trim Sequencer

This block finds the smallest read latency at which a memory read path still returns correct data. Software or a higher-level sequencer hands it a latency that is known to work and pulses `start`. The block then steps downward one cycle at a time. For each candidate it first places the value on `lat_out`, then raises `test_req` and waits for an external test engine to answer on `test_ack`/`test_pass`. The first failing candidate ends the search, as does reaching latency zero.

When the search is over, the block resets the read FIFO pointers with a pulse on `fifo_rst`. It then drives the final latency and reports the result with a one-cycle `done`. If at least one candidate passed, the final value is the lowest passing latency plus a guard margin of one further cycle. This equals the last tracked value plus `GUARD` (two by default), saturated at the register maximum, and `ok` is high. If the very first candidate failed, `ok` stays low and `lat_out` keeps the value that was tried. A `start` that arrives while a search is running has no effect.

Top module: `rdlat_seek`

## Requirements
- R1: After reset, `lat_out` is 0 and `test_req`, `fifo_rst`, `done` and `ok` are all low.
- R2: A `start` in idle begins a search at `init_lat`. Before every request, `lat_out` carries the candidate under test, and it stays unchanged while `test_req` is high. `test_req` stays high until `test_ack` is sampled high.
- R3: A passing answer at candidate L greater than 1 leads to a new request at L-1. A pass at L equal to 1 ends the search without testing 0. A pass at L equal to 0 also ends the search.
- R4: A failing answer (`test_ack` high, `test_pass` low) ends the search at once, and no further request is raised.
- R5: Every search, successful or not, is followed by exactly one `fifo_rst` pulse of `FLUSH_CYC` cycles. The pulse comes after the last request, and `done` follows it in the next cycle. `test_req`, `fifo_rst` and `done` are never high together.
- R6: When at least one candidate passed, the final `lat_out` is the last passing candidate minus 1 plus `GUARD` (a pass at 0 counts as 0 plus `GUARD`), saturated at 2^`LAT_W`-1. `ok` is high during `done`.
- R7: When the first candidate fails, `ok` is low during `done` and `lat_out` still holds `init_lat`.
- R8: `done` is high for exactly one cycle per search. A `start` seen while a search is running changes neither the candidate sequence nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled only when idle) |
| init_lat | input | LAT_W | Starting latency, known to work |
| test_ack | input | 1 | Test engine answer strobe |
| test_pass | input | 1 | Test result, valid with `test_ack` |
| lat_out | output | LAT_W | Latency presented to the read path |
| test_req | output | 1 | Request a read test at `lat_out` |
| fifo_rst | output | 1 | Read FIFO pointer reset pulse |
| done | output | 1 | One-cycle end-of-search strobe |
| ok | output | 1 | Search found a working latency (valid with `done`) |

## Verification
The bench builds the block with `LAT_W`=6, `GUARD`=2 and `FLUSH_CYC`=3. The 6-bit register makes the saturation of the guard margin reachable by starting at 63. The three-cycle flush makes a wrong pulse length visible. A threshold test engine in the bench answers after 0 to 3 cycles. This covers a long descent, a first-try failure, descents that run down to 1 and to 0, and a start pulse injected mid-search.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SET   = 3'd1,
    ST_REQ   = 3'd2,
    ST_FLUSH = 3'd3,
    ST_FIN   = 3'd4
  } seek_st_t;

  // Next lower candidate; zero stays at zero.
  function automatic int unsigned lat_step(int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  // True when the value after a pass is still worth testing.
  function automatic bit lat_more(int unsigned v);
    return v > 1;
  endfunction

  // Add the guard margin, saturating at the register maximum.
  function automatic int unsigned lat_guard(int unsigned v, int unsigned g,
                                            int unsigned maxv);
    return (v + g > maxv) ? maxv : v + g;
  endfunction

endpackage

// File: rtl/rdlat_fsm.sv
module rdlat_fsm
  import rdlat_pkg::*;
#(
  parameter int FLUSH_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic test_ack,
  input  logic test_pass,
  input  logic more,
  output logic ev_load,
  output logic ev_set,
  output logic ev_pass,
  output logic ev_finish,
  output logic test_req,
  output logic fifo_rst,
  output logic done
);

  localparam int CNT_W = (FLUSH_CYC < 2) ? 1 : $clog2(FLUSH_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLUSH_CYC - 1);

  seek_st_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic flush_last;

  assign flush_last = (st_q == ST_FLUSH) && (cnt_q == CNT_LAST);

  assign ev_load   = (st_q == ST_IDLE) && start;
  assign ev_set    = (st_q == ST_SET);
  assign ev_pass   = (st_q == ST_REQ) && test_ack && test_pass;
  assign ev_finish = flush_last;

  assign test_req = (st_q == ST_REQ);
  assign fifo_rst = (st_q == ST_FLUSH);
  assign done     = (st_q == ST_FIN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_SET;
      ST_SET:   st_d = ST_REQ;
      ST_REQ:   if (test_ack) st_d = (test_pass && more) ? ST_SET : ST_FLUSH;
      ST_FLUSH: if (flush_last) st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_FLUSH && !flush_last) cnt_q <= cnt_q + 1'b1;
      else                                  cnt_q <= '0;
    end
  end

endmodule

// File: rtl/rdlat_path.sv
module rdlat_path
  import rdlat_pkg::*;
#(
  parameter int LAT_W = 6,
  parameter int GUARD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] init_lat,
  input  logic             ev_load,
  input  logic             ev_set,
  input  logic             ev_pass,
  input  logic             ev_finish,
  output logic [LAT_W-1:0] lat_out,
  output logic             found,
  output logic             more
);

  localparam int unsigned LAT_MAX = (1 << LAT_W) - 1;

  logic [LAT_W-1:0] work_q;

  assign more = lat_more(32'(work_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      lat_out <= '0;
      found   <= 1'b0;
    end else begin
      if (ev_load) begin
        work_q <= init_lat;
        found  <= 1'b0;
      end else if (ev_pass) begin
        work_q <= LAT_W'(lat_step(32'(work_q)));
        found  <= 1'b1;
      end
      if (ev_set)
        lat_out <= work_q;
      else if (ev_finish && found)
        lat_out <= LAT_W'(lat_guard(32'(work_q), GUARD, LAT_MAX));
    end
  end

endmodule

// File: rtl/rdlat_seek.sv
module rdlat_seek #(
  parameter int LAT_W     = 6,
  parameter int GUARD     = 2,
  parameter int FLUSH_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] init_lat,
  input  logic             test_ack,
  input  logic             test_pass,
  output logic [LAT_W-1:0] lat_out,
  output logic             test_req,
  output logic             fifo_rst,
  output logic             done,
  output logic             ok
);

  logic ev_load, ev_set, ev_pass, ev_finish;
  logic found, more;

  rdlat_fsm #(.FLUSH_CYC(FLUSH_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .test_ack (test_ack),
    .test_pass(test_pass),
    .more     (more),
    .ev_load  (ev_load),
    .ev_set   (ev_set),
    .ev_pass  (ev_pass),
    .ev_finish(ev_finish),
    .test_req (test_req),
    .fifo_rst (fifo_rst),
    .done     (done)
  );

  rdlat_path #(.LAT_W(LAT_W), .GUARD(GUARD)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_lat (init_lat),
    .ev_load  (ev_load),
    .ev_set   (ev_set),
    .ev_pass  (ev_pass),
    .ev_finish(ev_finish),
    .lat_out  (lat_out),
    .found    (found),
    .more     (more)
  );

  assign ok = done && found;

endmodule

// File: rtl/rdlat_seek_chk.sv
module rdlat_seek_chk #(
  parameter int LAT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LAT_W-1:0] lat_out,
  input logic             test_req,
  input logic             test_ack,
  input logic             test_pass,
  input logic             fifo_rst,
  input logic             done,
  input logic             ok,
  input logic             ev_pass,
  input logic             more
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !test_ack |=> test_req);

  p_lat_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && $past(test_req) |-> $stable(lat_out));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass && more |=> !fifo_rst && !test_req && !done);

  p_last_pass_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass && !more |=> fifo_rst);

  p_fail_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && test_ack && !test_pass |=> fifo_rst);

  p_flush_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fifo_rst));

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_req, fifo_rst, done}));

  p_guard_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> lat_out > $past(lat_out));

  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok |-> $stable(lat_out));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind rdlat_seek rdlat_seek_chk #(.LAT_W(LAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lat_out  (lat_out),
  .test_req (test_req),
  .test_ack (test_ack),
  .test_pass(test_pass),
  .fifo_rst (fifo_rst),
  .done     (done),
  .ok       (ok),
  .ev_pass  (ev_pass),
  .more     (more)
);

// File: tb/test_rdlat_seek.sv
module test_rdlat_seek;

  localparam int LAT_W = 6;
  localparam int GUARD = 2;
  localparam int FLUSH_CYC = 3;

  // init, pass threshold, ack delay, expected lat, expected ok, expected test count
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{10, 4,  1, 5,  1, 8},
    '{10, 11, 0, 10, 0, 1},
    '{5,  0,  2, 2,  1, 5},
    '{1,  1,  3, 2,  1, 1},
    '{0,  0,  0, 2,  1, 1},
    '{63, 63, 1, 63, 1, 2},
    '{20, 20, 2, 21, 1, 2},
    '{0,  1,  1, 0,  0, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LAT_W-1:0] init_lat = '0;
  logic test_ack = 1'b0;
  logic test_pass = 1'b0;
  logic [LAT_W-1:0] lat_out;
  logic test_req, fifo_rst, done, ok;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rdlat_seek #(.LAT_W(LAT_W), .GUARD(GUARD), .FLUSH_CYC(FLUSH_CYC)) i_rdlat_seek (
    .clk(clk), .rst_n(rst_n), .start(start), .init_lat(init_lat),
    .test_ack(test_ack), .test_pass(test_pass), .lat_out(lat_out),
    .test_req(test_req), .fifo_rst(fifo_rst), .done(done), .ok(ok)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Run one search against a threshold test engine.
  task automatic run(input int init, input int thr, input int dly, input bit poke,
                     input int e_lat, input int e_ok, input int e_tests);
    int ntests = 0, nflush = 0, ndone = 0, seq_bad = 0, cnt = 0, tail = -1;
    int f_lat = -1, f_ok = -1;
    bit prev_req = 1'b0;
    @(negedge clk);
    init_lat = LAT_W'(init);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && tail != 0; i++) begin
      @(negedge clk);
      if (poke && i == 2) begin start = 1'b1; init_lat = 6'd33; end
      if (poke && i == 3) start = 1'b0;
      if (tail > 0) tail--;
      if (test_req) begin
        if (!prev_req) begin
          if (int'(lat_out) != init - ntests) seq_bad++;
          ntests++;
        end
        if (cnt == dly) begin
          test_ack = 1'b1;
          test_pass = int'(lat_out) >= thr;
          cnt = 0;
        end else begin
          test_ack = 1'b0;
          cnt++;
        end
      end else begin
        test_ack = 1'b0;
        test_pass = 1'b0;
        cnt = 0;
      end
      prev_req = test_req;
      if (fifo_rst) nflush++;
      if (done) begin
        ndone++;
        f_lat = int'(lat_out);
        f_ok = int'(ok);
        if (tail < 0) tail = 2;
      end
    end
    check(seq_bad == 0, "R2 candidate sequence", seq_bad, 0);
    if (e_ok != 0) check(ntests == e_tests, "R3 test count", ntests, e_tests);
    else           check(ntests == e_tests, "R4 test count", ntests, e_tests);
    check(nflush == FLUSH_CYC, "R5 flush cycles", nflush, FLUSH_CYC);
    check(ndone == 1, "R8 done cycles", ndone, 1);
    if (e_ok != 0) begin
      check(f_lat == e_lat, "R6 final latency", f_lat, e_lat);
      check(f_ok == 1, "R6 ok flag", f_ok, 1);
    end else begin
      check(f_lat == e_lat, "R7 held latency", f_lat, e_lat);
      check(f_ok == 0, "R7 ok flag", f_ok, 0);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(lat_out == '0, "R1 lat_out", int'(lat_out), 0);
    check({test_req, fifo_rst, done, ok} == 4'b0, "R1 control outputs",
          int'({test_req, fifo_rst, done, ok}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({test_req, fifo_rst, done} == 3'b0, "R1 idle after reset",
          int'({test_req, fifo_rst, done}), 0);

    for (int v = 0; v < NV; v++)
      run(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, VEC[v][3], VEC[v][4], VEC[v][5]);

    // R8: start pulse during a running search is ignored
    run(12, 9, 3, 1'b1, 10, 1, 5);

    // R7: lat_out keeps the failed value while idle afterwards
    run(40, 50, 1, 1'b0, 40, 0, 1);
    repeat (3) @(negedge clk);
    check(int'(lat_out) == 40, "R7 lat_out held in idle", int'(lat_out), 40);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule